// File: doc/BRIEF.md
# SMBus Block Transfer Engine

This engine adds block read and block write to a byte-level SMBus host. It keeps no data buffer. Every data byte passes through one block-data register, and software handshakes with the engine once per byte. After each data byte the engine sets a byte-done status flag. It then issues no further bus activity until software writes 1 to that flag. Before it clears the flag, software may load the next byte to send, or collect the byte that was received.

For a write, software places the byte count in data0 and the first data byte in the block-data register, then starts the engine. The engine sends the address, the command, the clamped count and the data bytes. For a read, the engine sends the address and the command, then sends a repeated start with the read address. The first byte returned is the count. The engine clamps it, stores it in data0, and hands each received byte to software in turn. The final byte is answered with NACK and followed by STOP. The engine drives a byte-level link below it, which performs one start, send, receive or stop operation per request.

Top module: `smb_blk_engine`

## Requirements
- R1: A control write (offset 2) starts a transfer only when its start bit (bit 6) is 1, its protocol field bits [4:2] equal 3'b101 (code 0x14, or 0x34 with bit 5 set), and status bits 0-4 and 7 (mask 0x9F) are all clear. Any other start attempt leaves busy (status bit 0) at 0 and issues no link request.
- R2: Link op codes are 0 = start and send byte, 1 = send byte, 2 = receive with ACK, 3 = receive with NACK, 4 = stop. A write (address register offset 4, bit 0 = 0) issues start {addr[7:1],0}, then send command (offset 3), then send count, where count is data0 (offset 5) clamped to the range 1..32.
- R3: After each data byte, status bit 7 (byte-done) is set. No link request is made while it is set. It is released by writing 1 to it.
- R4: Each write data byte sent is the block-data register value (offset 7) at the time the byte is requested.
- R5: A read (address bit 0 = 1) issues start {addr[7:1],0}, send command, start {addr[7:1],1}, then receive with ACK for the count byte. The count, clamped to 1..32, is stored in data0.
- R6: Each received data byte is readable at offset 7 while byte-done is set.
- R7: Every read data byte is answered with ACK except the final one, which uses NACK. A byte is final when the count is reached, or when the control protocol field holds the last-byte code (0x34) as the byte is requested.
- R8: Busy stays set for the whole block. After the final byte-done is released, stop is issued. On its completion, status bit 1 (interrupt) is set and busy is cleared.
- R9: A device NACK on a sent byte (status bit 2), a collision (bit 3) or a link failure (bit 4) on any byte aborts the block. The flag is set, stop is issued, no further byte follows, and the interrupt flag stays 0.
- R10: Status bits 1, 2, 3, 4 and 7 are cleared only by writing 1 to them. Writing 0 leaves them unchanged.
- R11: A 32-byte block gives exactly 32 byte-done events after the count byte.
- R12: After reset, status and data registers read 0 and no link request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Register write strobe |
| sw_waddr | input | 4 | Register write offset |
| sw_wdata | input | 8 | Register write data |
| sw_raddr | input | 4 | Register read offset |
| sw_rdata | output | 8 | Register read data (combinational) |
| lk_req | output | 1 | Link operation request, held until done |
| lk_op | output | 3 | Link operation code |
| lk_wdata | output | 8 | Byte to send |
| lk_done | input | 1 | Link operation completed (one cycle) |
| lk_rdata | input | 8 | Byte received, valid with lk_done |
| lk_nak | input | 1 | Slave did not acknowledge a sent byte |
| lk_col | input | 1 | Bus collision |
| lk_fail | input | 1 | Link operation failed |

## Verification
The link request for the address byte appears in the cycle after the start write's clock edge. Each status flag is set on the same edge that captures lk_done, so it can be read in that cycle's second half. After a byte-done release is written, the next request appears two edges later. The bench stub answers each request a fixed latency after it first sees it. It compares the operation and byte against a queue built behaviourally from the requirements. The bench reads registers through the combinational read port at falling edges, so each result is taken one half-cycle after the edge that produced it.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    typedef enum logic [2:0] {
        LK_START     = 3'd0,
        LK_SEND      = 3'd1,
        LK_RECV_ACK  = 3'd2,
        LK_RECV_NACK = 3'd3,
        LK_STOP      = 3'd4
    } link_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_RADDR,
        ST_CNT,
        ST_DATA,
        ST_HOLD,
        ST_STOP
    } seq_state_e;

    // register offsets
    localparam logic [3:0] OFS_STAT = 4'd0;
    localparam logic [3:0] OFS_CTRL = 4'd2;
    localparam logic [3:0] OFS_CMD  = 4'd3;
    localparam logic [3:0] OFS_ADDR = 4'd4;
    localparam logic [3:0] OFS_D0   = 4'd5;
    localparam logic [3:0] OFS_BLK  = 4'd7;

    // status bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_INTR  = 1;
    localparam int SB_DEV   = 2;
    localparam int SB_BUS   = 3;
    localparam int SB_FAIL  = 4;
    localparam int SB_BDONE = 7;

    // control fields
    localparam int         CB_START   = 6;
    localparam int         CB_LAST    = 5;
    localparam logic [2:0] PROTO_BLOCK = 3'b101;

    // flags that must be clear before a block may begin
    localparam logic [7:0] IDLE_MASK = 8'h9F;

    typedef struct packed {
        logic intr;
        logic dev;
        logic bus;
        logic fail;
        logic bdone;
    } stat_set_t;

    function automatic logic [7:0] clamp_count(input logic [7:0] v,
                                               input logic [7:0] lo,
                                               input logic [7:0] hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/smb_blk_regs.sv
module smb_blk_regs
    import smb_blk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    input  stat_set_t  set_i,
    input  logic       busy_i,
    input  logic       d0_load_i,
    input  logic [7:0] d0_val_i,
    input  logic       blk_load_i,
    input  logic [7:0] blk_val_i,
    output logic       start_req_o,
    output logic [7:0] ctrl_o,
    output logic [7:0] cmd_o,
    output logic [7:0] addr_o,
    output logic [7:0] data0_o,
    output logic [7:0] blk_o,
    output logic [7:0] stat_o
);

    logic [7:0] ctrl_q, cmd_q, addr_q, d0_q, blk_q;
    logic       intr_q, dev_q, bus_q, fail_q, bdone_q;
    logic       wr_stat;

    assign wr_stat = wr_en && (wr_addr == OFS_STAT);

    assign start_req_o = wr_en && (wr_addr == OFS_CTRL) && wr_data[CB_START]
                         && (wr_data[4:2] == PROTO_BLOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            d0_q   <= '0;
            blk_q  <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    OFS_CTRL: ctrl_q <= wr_data & ~(8'h1 << CB_START);
                    OFS_CMD:  cmd_q  <= wr_data;
                    OFS_ADDR: addr_q <= wr_data;
                    OFS_D0:   d0_q   <= wr_data;
                    OFS_BLK:  blk_q  <= wr_data;
                    default: ;
                endcase
            end
            if (d0_load_i)  d0_q  <= d0_val_i;
            if (blk_load_i) blk_q <= blk_val_i;
        end
    end

    // write-1-to-clear flags; a set from the engine wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            intr_q  <= 1'b0;
            dev_q   <= 1'b0;
            bus_q   <= 1'b0;
            fail_q  <= 1'b0;
            bdone_q <= 1'b0;
        end else begin
            intr_q  <= set_i.intr  | (intr_q  & ~(wr_stat & wr_data[SB_INTR]));
            dev_q   <= set_i.dev   | (dev_q   & ~(wr_stat & wr_data[SB_DEV]));
            bus_q   <= set_i.bus   | (bus_q   & ~(wr_stat & wr_data[SB_BUS]));
            fail_q  <= set_i.fail  | (fail_q  & ~(wr_stat & wr_data[SB_FAIL]));
            bdone_q <= set_i.bdone | (bdone_q & ~(wr_stat & wr_data[SB_BDONE]));
        end
    end

    assign stat_o  = {bdone_q, 2'b00, fail_q, bus_q, dev_q, intr_q, busy_i};
    assign ctrl_o  = ctrl_q;
    assign cmd_o   = cmd_q;
    assign addr_o  = addr_q;
    assign data0_o = d0_q;
    assign blk_o   = blk_q;

    always_comb begin
        unique case (rd_addr)
            OFS_STAT: rd_data = stat_o;
            OFS_CTRL: rd_data = ctrl_q;
            OFS_CMD:  rd_data = cmd_q;
            OFS_ADDR: rd_data = addr_q;
            OFS_D0:   rd_data = d0_q;
            OFS_BLK:  rd_data = blk_q;
            default:  rd_data = 8'h00;
        endcase
    end

    // R8: the interrupt flag rises only once the engine has gone idle
    p_intr_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_q) |-> !busy_i);

    // R10: byte-done falls only after a write of 1 to it
    p_bdone_w1c_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(bdone_q) |-> $past(wr_stat && wr_data[SB_BDONE]));

endmodule

// File: rtl/smb_blk_seq.sv
module smb_blk_seq
    import smb_blk_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int MIN_LEN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req_i,
    input  logic [7:0] ctrl_i,
    input  logic [7:0] cmd_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] data0_i,
    input  logic [7:0] blk_i,
    input  logic [7:0] stat_i,
    output logic       lk_req_o,
    output logic [2:0] lk_op_o,
    output logic [7:0] lk_wdata_o,
    input  logic       lk_done_i,
    input  logic [7:0] lk_rdata_i,
    input  logic       lk_nak_i,
    input  logic       lk_col_i,
    input  logic       lk_fail_i,
    output stat_set_t  set_o,
    output logic       d0_load_o,
    output logic [7:0] d0_val_o,
    output logic       blk_load_o,
    output logic [7:0] blk_val_o,
    output logic       busy_o
);

    localparam int         IW = $clog2(MAX_LEN + 1);
    localparam logic [7:0] LO = 8'(MIN_LEN);
    localparam logic [7:0] HI = 8'(MAX_LEN);

    seq_state_e     st_q;
    logic [7:0]     tgt_q, cmd_q;
    logic           rd_q, fin_q, abort_q;
    logic [IW-1:0]  len_q, idx_q;

    link_op_e       op;
    logic [7:0]     wd;
    logic           req, last_now, is_tx, err_now, step;

    assign last_now = (idx_q == len_q - IW'(1)) || (rd_q && ctrl_i[CB_LAST]);

    always_comb begin
        op  = LK_STOP;
        wd  = 8'h00;
        req = 1'b1;
        unique case (st_q)
            ST_ADDR:  begin op = LK_START; wd = {tgt_q[7:1], 1'b0}; end
            ST_CMD:   begin op = LK_SEND;  wd = cmd_q; end
            ST_RADDR: begin op = LK_START; wd = {tgt_q[7:1], 1'b1}; end
            ST_CNT: begin
                if (rd_q) op = LK_RECV_ACK;
                else begin op = LK_SEND; wd = 8'(len_q); end
            end
            ST_DATA: begin
                if (rd_q) op = last_now ? LK_RECV_NACK : LK_RECV_ACK;
                else begin op = LK_SEND; wd = blk_i; end
            end
            ST_STOP:  op = LK_STOP;
            default:  req = 1'b0;
        endcase
    end

    assign is_tx   = (op == LK_START) || (op == LK_SEND);
    assign step    = lk_done_i && req;
    assign err_now = step && (st_q != ST_STOP)
                     && (lk_fail_i || lk_col_i || (lk_nak_i && is_tx));

    always_comb begin
        set_o       = '0;
        set_o.dev   = err_now && lk_nak_i && is_tx;
        set_o.bus   = err_now && lk_col_i;
        set_o.fail  = err_now && lk_fail_i;
        set_o.bdone = step && (st_q == ST_DATA) && !err_now;
        set_o.intr  = step && (st_q == ST_STOP) && !abort_q;
    end

    assign d0_load_o  = step && (st_q == ST_CNT) && rd_q && !err_now;
    assign d0_val_o   = clamp_count(lk_rdata_i, LO, HI);
    assign blk_load_o = set_o.bdone && rd_q;
    assign blk_val_o  = lk_rdata_i;

    assign lk_req_o   = req;
    assign lk_op_o    = op;
    assign lk_wdata_o = wd;
    assign busy_o     = (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tgt_q   <= '0;
            cmd_q   <= '0;
            rd_q    <= 1'b0;
            fin_q   <= 1'b0;
            abort_q <= 1'b0;
            len_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_req_i && ((stat_i & IDLE_MASK) == 8'h00)) begin
                        st_q    <= ST_ADDR;
                        tgt_q   <= addr_i;
                        cmd_q   <= cmd_i;
                        rd_q    <= addr_i[0];
                        idx_q   <= '0;
                        fin_q   <= 1'b0;
                        abort_q <= 1'b0;
                        len_q   <= IW'(clamp_count(data0_i, LO, HI));
                    end
                end
                ST_HOLD: begin
                    if (!stat_i[SB_BDONE]) st_q <= fin_q ? ST_STOP : ST_DATA;
                end
                default: begin
                    if (err_now) begin
                        abort_q <= 1'b1;
                        st_q    <= ST_STOP;
                    end else if (step) begin
                        unique case (st_q)
                            ST_ADDR:  st_q <= ST_CMD;
                            ST_CMD:   st_q <= rd_q ? ST_RADDR : ST_CNT;
                            ST_RADDR: st_q <= ST_CNT;
                            ST_CNT: begin
                                if (rd_q) len_q <= IW'(d0_val_o);
                                st_q <= ST_DATA;
                            end
                            ST_DATA: begin
                                idx_q <= idx_q + IW'(1);
                                fin_q <= last_now;
                                st_q  <= ST_HOLD;
                            end
                            ST_STOP:  st_q <= ST_IDLE;
                            default:  st_q <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // R2: a pending link request keeps its operation and byte until done
    p_req_stable_r2: assert property (@(posedge clk) disable iff (rst)
        lk_req_o && !lk_done_i |=> lk_req_o && $stable(lk_op_o) && $stable(lk_wdata_o));

    // R3: no link activity while byte-done is pending
    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        stat_i[SB_BDONE] |-> !lk_req_o);

    // R1: a start refused by the idle mask leaves the engine idle
    p_refuse_r1: assert property (@(posedge clk) disable iff (rst)
        start_req_i && ((stat_i & IDLE_MASK) != 8'h00) && !busy_o |=> !busy_o);

    // R9: a collision on a data-phase op is followed by a stop request
    p_abort_stop_r9: assert property (@(posedge clk) disable iff (rst)
        lk_req_o && lk_done_i && lk_col_i && (lk_op_o != 3'(LK_STOP))
        |=> lk_req_o && (lk_op_o == 3'(LK_STOP)));

    // R11: the byte index never passes the block length
    p_idx_bound_r11: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> idx_q <= len_q);

endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine
    import smb_blk_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int MIN_LEN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_we,
    input  logic [3:0] sw_waddr,
    input  logic [7:0] sw_wdata,
    input  logic [3:0] sw_raddr,
    output logic [7:0] sw_rdata,
    output logic       lk_req,
    output logic [2:0] lk_op,
    output logic [7:0] lk_wdata,
    input  logic       lk_done,
    input  logic [7:0] lk_rdata,
    input  logic       lk_nak,
    input  logic       lk_col,
    input  logic       lk_fail
);

    stat_set_t  set_w;
    logic       busy_w, start_w, d0_load_w, blk_load_w;
    logic [7:0] d0_val_w, blk_val_w;
    logic [7:0] ctrl_w, cmd_w, addr_w, data0_w, blk_w, stat_w;

    smb_blk_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (sw_we),
        .wr_addr    (sw_waddr),
        .wr_data    (sw_wdata),
        .rd_addr    (sw_raddr),
        .rd_data    (sw_rdata),
        .set_i      (set_w),
        .busy_i     (busy_w),
        .d0_load_i  (d0_load_w),
        .d0_val_i   (d0_val_w),
        .blk_load_i (blk_load_w),
        .blk_val_i  (blk_val_w),
        .start_req_o(start_w),
        .ctrl_o     (ctrl_w),
        .cmd_o      (cmd_w),
        .addr_o     (addr_w),
        .data0_o    (data0_w),
        .blk_o      (blk_w),
        .stat_o     (stat_w)
    );

    smb_blk_seq #(
        .MAX_LEN(MAX_LEN),
        .MIN_LEN(MIN_LEN)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req_i(start_w),
        .ctrl_i     (ctrl_w),
        .cmd_i      (cmd_w),
        .addr_i     (addr_w),
        .data0_i    (data0_w),
        .blk_i      (blk_w),
        .stat_i     (stat_w),
        .lk_req_o   (lk_req),
        .lk_op_o    (lk_op),
        .lk_wdata_o (lk_wdata),
        .lk_done_i  (lk_done),
        .lk_rdata_i (lk_rdata),
        .lk_nak_i   (lk_nak),
        .lk_col_i   (lk_col),
        .lk_fail_i  (lk_fail),
        .set_o      (set_w),
        .d0_load_o  (d0_load_w),
        .d0_val_o   (d0_val_w),
        .blk_load_o (blk_load_w),
        .blk_val_o  (blk_val_w),
        .busy_o     (busy_w)
    );

endmodule

// File: tb/tb_smb_blk_engine.sv
module tb_smb_blk_engine;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       sw_we;
    logic [3:0] sw_waddr, sw_raddr;
    logic [7:0] sw_wdata;
    logic [7:0] sw_rdata;
    logic       lk_req;
    logic [2:0] lk_op;
    logic [7:0] lk_wdata;
    logic       lk_done, lk_nak, lk_col, lk_fail;
    logic [7:0] lk_rdata;

    int n_chk = 0;
    int n_err = 0;
    int n_ops = 0;
    string cur_tag = "R12";

    int q_op[$], q_b[$], q_e[$];
    int t_op[$], t_b[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_blk_engine dut (
        .clk(clk), .rst(rst),
        .sw_we(sw_we), .sw_waddr(sw_waddr), .sw_wdata(sw_wdata),
        .sw_raddr(sw_raddr), .sw_rdata(sw_rdata),
        .lk_req(lk_req), .lk_op(lk_op), .lk_wdata(lk_wdata),
        .lk_done(lk_done), .lk_rdata(lk_rdata),
        .lk_nak(lk_nak), .lk_col(lk_col), .lk_fail(lk_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_waddr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        sw_raddr = a;
        #1 v = sw_rdata;
    endtask

    task automatic poll(output logic [7:0] s);
        s = 8'h00;
        for (int k = 0; k < 3000; k++) begin
            sw_read(4'd0, s);
            if (s[7] || !s[0]) return;
        end
        chk(1'b0, {cur_tag, " poll timeout"}, s, 0);
    endtask

    function automatic void tpush(input int op, input int b);
        t_op.push_back(op); t_b.push_back(b);
    endfunction

    // move the planned ops into the live queue; an error cuts it short with a stop
    function automatic void commit(input int err_at, input int kind);
        for (int t = 0; t < t_op.size(); t++) begin
            if (t == err_at) begin
                q_op.push_back(t_op[t]); q_b.push_back(t_b[t]); q_e.push_back(kind);
                q_op.push_back(4); q_b.push_back(0); q_e.push_back(0);
                break;
            end
            q_op.push_back(t_op[t]); q_b.push_back(t_b[t]); q_e.push_back(0);
        end
        t_op.delete(); t_b.delete();
    endfunction

    function automatic int clampc(input int v);
        return (v < 1) ? 1 : ((v > 32) ? 32 : v);
    endfunction

    function automatic int errbit(input int kind);
        return (kind == 1) ? 8'h04 : (kind == 2) ? 8'h08 : (kind == 3) ? 8'h10 : 8'h02;
    endfunction

    function automatic logic [7:0] wbyte(input int cmd, input int i);
        return 8'(cmd + 17 * i);
    endfunction

    function automatic logic [7:0] rbyte(input int i);
        return 8'(8'h5A ^ (i * 7));
    endfunction

    // link stub: checks each request against the model queue and answers it
    initial begin
        lk_done = 0; lk_nak = 0; lk_col = 0; lk_fail = 0; lk_rdata = 0;
        forever begin
            @(negedge clk);
            if (lk_req && !rst) begin
                int eop, eb, ee;
                n_ops++;
                if (q_op.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected link request"}, lk_op, 7);
                    eop = 4; eb = 0; ee = 0;
                end else begin
                    eop = q_op.pop_front(); eb = q_b.pop_front(); ee = q_e.pop_front();
                    chk(lk_op == 3'(eop), {cur_tag, " link op"}, lk_op, eop);
                    if (eop <= 1)
                        chk(lk_wdata == 8'(eb), {cur_tag, " link byte (R4)"}, lk_wdata, eb);
                end
                repeat (LAT - 1) @(negedge clk);
                lk_rdata = (eop == 2 || eop == 3) ? 8'(eb) : 8'h00;
                lk_nak   = (ee == 1);
                lk_col   = (ee == 2);
                lk_fail  = (ee == 3);
                lk_done  = 1'b1;
                @(negedge clk);
                lk_done = 0; lk_nak = 0; lk_col = 0; lk_fail = 0;
            end
        end
    end

    task automatic run_write(input string tag, input int a7, input int cmd, input int d0,
                             input int err_at, input int kind);
        int n, bd, exp_bd;
        logic [7:0] s;
        cur_tag = tag;
        n = clampc(d0);
        tpush(0, {a7[6:0], 1'b0});
        tpush(1, cmd);
        tpush(1, n);
        for (int i = 0; i < n; i++) tpush(1, wbyte(cmd, i));
        tpush(4, 0);
        commit(err_at, kind);
        sw_write(4'd3, 8'(cmd));
        sw_write(4'd4, {a7[6:0], 1'b0});
        sw_write(4'd5, 8'(d0));
        sw_write(4'd7, wbyte(cmd, 0));
        sw_write(4'd2, 8'h54);
        bd = 0;
        for (int i = 0; i < 40; i++) begin
            poll(s);
            if (!s[7]) break;
            bd++;
            if (i == 0) begin
                // R3: stalled while byte-done is set
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    chk(!lk_req, {tag, " R3 stall"}, lk_req, 0);
                end
            end
            if (i + 1 < n) sw_write(4'd7, wbyte(cmd, i + 1));
            sw_write(4'd0, 8'h80);
        end
        exp_bd = (kind == 0) ? n : ((err_at > 3) ? err_at - 3 : 0);
        chk(bd == exp_bd, {tag, " byte-done count (R3/R11)"}, bd, exp_bd);
        chk(s == 8'(errbit(kind)), {tag, " final status (R8/R9)"}, s, errbit(kind));
        chk(q_op.size() == 0, {tag, " all ops issued (R2)"}, q_op.size(), 0);
    endtask

    task automatic run_read(input string tag, input int a7, input int cmd, input int scnt,
                            input int early, input int err_at, input int kind);
        int n, bd, exp_bd;
        logic [7:0] s, v;
        cur_tag = tag;
        n = clampc(scnt);
        if (early >= 2 && early < n) n = early;
        tpush(0, {a7[6:0], 1'b0});
        tpush(1, cmd);
        tpush(0, {a7[6:0], 1'b1});
        tpush(2, scnt);
        for (int i = 0; i < n; i++) tpush((i == n - 1) ? 3 : 2, rbyte(i));
        tpush(4, 0);
        commit(err_at, kind);
        sw_write(4'd3, 8'(cmd));
        sw_write(4'd4, {a7[6:0], 1'b1});
        sw_write(4'd2, 8'h54);
        bd = 0;
        for (int i = 0; i < 40; i++) begin
            poll(s);
            if (!s[7]) break;
            bd++;
            sw_read(4'd7, v);
            chk(v == rbyte(i), {tag, " R6 received byte"}, v, rbyte(i));
            if (i == 0) begin
                sw_read(4'd5, v);
                chk(v == 8'(clampc(scnt)), {tag, " R5 stored count"}, v, clampc(scnt));
            end
            if (early >= 2 && i == n - 2) sw_write(4'd2, 8'h34);
            sw_write(4'd0, 8'h80);
        end
        exp_bd = (kind == 0) ? n : ((err_at > 4) ? err_at - 4 : 0);
        chk(bd == exp_bd, {tag, " byte-done count (R11)"}, bd, exp_bd);
        chk(s == 8'(errbit(kind)), {tag, " final status (R8/R9)"}, s, errbit(kind));
        chk(q_op.size() == 0, {tag, " ACK/NACK ops issued (R7)"}, q_op.size(), 0);
    endtask

    task automatic clear_all();
        sw_write(4'd0, 8'hFF);
    endtask

    task automatic run_tests();
        logic [7:0] v;
        int ops0;
        sw_we = 0; sw_waddr = 0; sw_wdata = 0; sw_raddr = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        sw_read(4'd0, v); chk(v == 8'h00, "R12 status", v, 0);
        sw_read(4'd5, v); chk(v == 8'h00, "R12 data0", v, 0);
        chk(!lk_req, "R12 no request", lk_req, 0);

        // R1 wrong protocol code is ignored
        cur_tag = "R1";
        ops0 = n_ops;
        sw_write(4'd2, 8'h48);
        repeat (8) @(negedge clk);
        sw_read(4'd0, v);
        chk(v == 8'h00, "R1 non-block code busy", v, 0);
        chk(n_ops == ops0, "R1 non-block code link", n_ops, ops0);

        // R2/R4 basic write, then clamping of the count
        run_write("R2 write3", 7'h2C, 8'h11, 3, -1, 0);
        clear_all();
        run_write("R2 write clamp low", 7'h15, 8'h22, 0, -1, 0);
        clear_all();
        run_write("R11 write 32 clamp high", 7'h40, 8'h33, 40, -1, 0);
        clear_all();

        // R5/R6/R7 reads
        run_read("R5 read4", 7'h50, 8'h44, 4, 0, -1, 0);
        clear_all();
        run_read("R5 read clamp low", 7'h51, 8'h45, 0, 0, -1, 0);
        clear_all();
        run_read("R11 read 32 clamp high", 7'h52, 8'h46, 50, 0, -1, 0);
        clear_all();
        run_read("R7 early last-byte code", 7'h53, 8'h47, 6, 3, -1, 0);
        clear_all();

        // R9 aborts
        run_write("R9 nak on data byte", 7'h20, 8'h55, 4, 4, 1);
        // R1: start refused while an error flag is set
        cur_tag = "R1";
        ops0 = n_ops;
        sw_write(4'd2, 8'h54);
        repeat (8) @(negedge clk);
        sw_read(4'd0, v);
        chk(v == 8'h04, "R1 refused with error flag", v, 8'h04);
        chk(n_ops == ops0, "R1 refused no link", n_ops, ops0);
        // R10 write-0 keeps, write-1 clears
        sw_write(4'd0, 8'h00);
        sw_read(4'd0, v); chk(v == 8'h04, "R10 write 0 keeps", v, 8'h04);
        sw_write(4'd0, 8'h04);
        sw_read(4'd0, v); chk(v == 8'h00, "R10 write 1 clears", v, 0);

        run_write("R9 collision on address", 7'h21, 8'h56, 2, 0, 2);
        clear_all();
        run_read("R9 failure on count", 7'h22, 8'h57, 5, 0, 3, 3);
        clear_all();
        run_read("R9 failure mid read", 7'h23, 8'h58, 5, 0, 6, 3);
        clear_all();
        sw_read(4'd0, v); chk(v == 8'h00, "R10 all cleared", v, 0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            run_tests();
            begin
                repeat (WDOG) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "watchdog expired", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule